// File: doc/BRIEF.md
# FMA Special-Operand Result Selector

This combinational block sits in front of a double-precision fused multiply-add datapath that computes z + x*y. It takes the three raw operand encodings and classifies each one as zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes and the signs, it decides whether the result is already fixed by the special-operand rules.

When the result is fixed, the block drives that result and an invalid-operation flag, and it keeps the arithmetic datapath idle. When the result is not fixed, it raises a compute enable and says which operands must be normalized from subnormal form before the datapath uses them. Rounding and the arithmetic itself are handled elsewhere.

NaN and infinity priority is resolved across all three operands. A signalling-NaN addend outranks everything. The addend's class can also replace the outcome of the product's special cases.

Top module: `fma_special_sel`

## Requirements
- R1: If z is a signalling NaN, the result is fixed, invalid is raised, and the result is z with fraction bit 51 set. This holds whatever x and y are.
- R2: Otherwise, if x is a signalling NaN, the result is x with bit 51 set. If y is a signalling NaN and x is not, the result is y with bit 51 set. In both cases invalid is raised.
- R3: Otherwise, if x is a quiet NaN, the result is x unchanged. If y is a quiet NaN and x is not a NaN, the result is y unchanged. Invalid stays low.
- R4: If one multiplicand is infinite and the other is zero, a quiet-NaN z is returned unchanged. Otherwise invalid is raised and the default NaN is returned.
- R5: If one multiplicand is infinite and the other is nonzero and not a NaN, a quiet-NaN z is returned unchanged. Otherwise the result is infinity with sign x[63] XOR y[63], unless R6 applies.
- R6: In the R5 case, if z is infinity with the opposite sign to the product, invalid is raised and the default NaN is returned.
- R7: If one multiplicand is zero and the other is finite, the result is z unchanged, with no invalid. If z is infinite, this is infinity with z's sign.
- R8: If both multiplicands are finite and nonzero, a quiet-NaN z is returned unchanged, and an infinite z gives infinity with z's sign.
- R9: In all other finite cases, compute is high and fixed is low, which makes the two mutually exclusive. The normalize request for each operand is high exactly when that operand is subnormal.
- R10: Classification works as follows:
  - An exponent (bits 62:52) of all ones with a zero fraction is infinity.
  - An exponent of all ones with fraction bit 51 set is a quiet NaN.
  - An exponent of all ones with bit 51 clear and some other fraction bit set is a signalling NaN.
  - An exponent of zero is zero when the fraction is zero and subnormal when it is not.
- R11: The default NaN is 0x7FF8000000000000. Invalid is never raised when compute is high, and the result reads zero then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 64 | Multiplicand x, raw encoding |
| op_y | input | 64 | Multiplicand y, raw encoding |
| op_z | input | 64 | Addend z, raw encoding |
| fixed_o | output | 1 | Result is determined by special-operand rules |
| result_o | output | 64 | Fixed result (zero when compute_o is high) |
| invalid_o | output | 1 | Invalid-operation flag |
| compute_o | output | 1 | Arithmetic datapath must run |
| norm_x_o | output | 1 | x needs subnormal normalization |
| norm_y_o | output | 1 | y needs subnormal normalization |
| norm_z_o | output | 1 | z needs subnormal normalization |

## Verification
The hardest outcome to reach is the invalid result from an infinite product meeting an infinite addend of the opposite sign. It needs three independent classes and a specific sign relation at the same time. The stimulus therefore sweeps every ordered triple of the six classes under all eight sign combinations, so this case and its same-sign twin are each hit deterministically. Boundary encodings around the quiet bit (only bit 51 set, only bit 0 set) are then applied directly to pin down classification.

// File: rtl/fma_special_sel.sv
`timescale 1ns/1ps
module fma_special_sel #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_x,
  input  logic [EXP_W+FRAC_W:0] op_y,
  input  logic [EXP_W+FRAC_W:0] op_z,
  output logic                  fixed_o,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic                  invalid_o,
  output logic                  compute_o,
  output logic                  norm_x_o,
  output logic                  norm_y_o,
  output logic                  norm_z_o
);
  localparam int DW = EXP_W + FRAC_W + 1;
  localparam logic [DW-1:0] QMASK = DW'(1) << (FRAC_W - 1);
  localparam logic [DW-1:0] DNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {C_ZERO, C_SUB, C_NORM, C_INF, C_QNAN, C_SNAN} cls_t;

  function automatic cls_t classify(input logic [DW-1:0] v);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    e = v[DW-2:FRAC_W];
    f = v[FRAC_W-1:0];
    if (&e)       return (f == '0) ? C_INF : (f[FRAC_W-1] ? C_QNAN : C_SNAN);
    else if (e == '0) return (f == '0) ? C_ZERO : C_SUB;
    else          return C_NORM;
  endfunction

  function automatic logic [DW-1:0] inf_of(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  cls_t cx, cy, cz;
  logic ps, zs;
  assign cx = classify(op_x);
  assign cy = classify(op_y);
  assign cz = classify(op_z);
  assign ps = op_x[DW-1] ^ op_y[DW-1];
  assign zs = op_z[DW-1];

  logic fix, inv;
  logic [DW-1:0] res;

  always_comb begin
    fix = 1'b1;
    inv = 1'b0;
    res = '0;
    if (cz == C_SNAN) begin
      inv = 1'b1;
      res = op_z | QMASK;
    end else if (cx == C_SNAN) begin
      inv = 1'b1;
      res = op_x | QMASK;
    end else if (cy == C_SNAN) begin
      inv = 1'b1;
      res = op_y | QMASK;
    end else if (cx == C_QNAN) begin
      res = op_x;
    end else if (cy == C_QNAN) begin
      res = op_y;
    end else if ((cx == C_INF && cy == C_ZERO) || (cx == C_ZERO && cy == C_INF)) begin
      if (cz == C_QNAN) res = op_z;
      else begin
        inv = 1'b1;
        res = DNAN;
      end
    end else if (cx == C_INF || cy == C_INF) begin
      if (cz == C_QNAN) res = op_z;
      else if (cz == C_INF && zs != ps) begin
        inv = 1'b1;
        res = DNAN;
      end else res = inf_of(ps);
    end else if (cx == C_ZERO || cy == C_ZERO) begin
      res = (cz == C_INF) ? inf_of(zs) : op_z;
    end else if (cz == C_QNAN) begin
      res = op_z;
    end else if (cz == C_INF) begin
      res = inf_of(zs);
    end else begin
      fix = 1'b0;
    end
  end

  assign fixed_o   = fix;
  assign result_o  = res;
  assign invalid_o = inv;
  assign compute_o = !fix;
  assign norm_x_o  = !fix && cx == C_SUB;
  assign norm_y_o  = !fix && cy == C_SUB;
  assign norm_z_o  = !fix && cz == C_SUB;
endmodule

// File: rtl/fma_special_sel_chk.sv
`timescale 1ns/1ps
module fma_special_sel_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic [EXP_W+FRAC_W:0] op_x,
  input logic [EXP_W+FRAC_W:0] op_y,
  input logic [EXP_W+FRAC_W:0] op_z,
  input logic                  fixed_o,
  input logic [EXP_W+FRAC_W:0] result_o,
  input logic                  invalid_o,
  input logic                  compute_o,
  input logic                  norm_x_o,
  input logic                  norm_y_o,
  input logic                  norm_z_o
);
  localparam int DW = EXP_W + FRAC_W + 1;
  localparam logic [DW-1:0] QMASK = DW'(1) << (FRAC_W - 1);
  localparam logic [DW-1:0] DNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic xe1, ye1, ze1, xf0, yf0, zf0;
  assign xe1 = &op_x[DW-2:FRAC_W];
  assign ye1 = &op_y[DW-2:FRAC_W];
  assign ze1 = &op_z[DW-2:FRAC_W];
  assign xf0 = op_x[FRAC_W-1:0] == '0;
  assign yf0 = op_y[FRAC_W-1:0] == '0;
  assign zf0 = op_z[FRAC_W-1:0] == '0;

  logic z_snan, z_nan, x_inf, y_zero, y_norm, z_inf, z_norm, x_zero;
  assign z_snan = ze1 && !zf0 && !op_z[FRAC_W-1];
  assign z_nan  = ze1 && !zf0;
  assign z_inf  = ze1 && zf0;
  assign z_norm = !ze1 && op_z[DW-2:FRAC_W] != '0;
  assign x_inf  = xe1 && xf0;
  assign x_zero = op_x[DW-2:0] == '0;
  assign y_zero = op_y[DW-2:0] == '0;
  assign y_norm = !ye1 && op_y[DW-2:FRAC_W] != '0;

  always_comb begin
    if (z_snan)
      a_r1_snan_addend: assert (fixed_o && invalid_o && result_o == (op_z | QMASK));
    if (x_inf && y_zero && !z_nan)
      a_r4_inf_times_zero: assert (invalid_o && result_o == DNAN);
    if (x_inf && y_norm && z_inf && op_z[DW-1] != (op_x[DW-1] ^ op_y[DW-1]))
      a_r6_opposite_inf: assert (invalid_o && result_o == DNAN);
    if (x_zero && y_norm && z_norm)
      a_r7_zero_product: assert (fixed_o && !invalid_o && result_o == op_z);
    a_r9_exclusive: assert (fixed_o != compute_o);
    if (norm_x_o || norm_y_o || norm_z_o)
      a_r9_norm_gated: assert (compute_o);
    if (compute_o)
      a_r11_quiet_compute: assert (!invalid_o && result_o == '0);
  end
endmodule

bind fma_special_sel fma_special_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .op_x(op_x), .op_y(op_y), .op_z(op_z), .fixed_o(fixed_o), .result_o(result_o),
  .invalid_o(invalid_o), .compute_o(compute_o), .norm_x_o(norm_x_o),
  .norm_y_o(norm_y_o), .norm_z_o(norm_z_o)
);

// File: tb/fma_special_sel_tb_top.sv
`timescale 1ns/1ps
module fma_special_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] x, y, z, res;
  logic fixd, inv, comp, nx, ny, nz;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  string label_override = "";

  fma_special_sel dut_i (
    .op_x(x), .op_y(y), .op_z(z), .fixed_o(fixd), .result_o(res), .invalid_o(inv),
    .compute_o(comp), .norm_x_o(nx), .norm_y_o(ny), .norm_z_o(nz)
  );

  // class codes: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan
  function automatic int cls(input logic [63:0] v);
    int e = int'(v[62:52]);
    if (e == 2047) begin
      if (v[51:0] == 0) return 3;
      return v[51] ? 4 : 5;
    end
    if (e == 0) return (v[51:0] == 0) ? 0 : 1;
    return 2;
  endfunction

  function automatic logic [63:0] mk(input int c, input bit s);
    logic [51:0] f;
    logic [10:0] e;
    f = {$urandom, $urandom};
    e = 11'($urandom_range(2046, 1));
    case (c)
      0: return {s, 63'd0};
      1: return {s, 11'd0, f | 52'd1};
      2: return {s, e, f};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, f[50:0]};
      default: return {s, 11'h7FF, 1'b0, f[50:0] | 51'd1};
    endcase
  endfunction

  localparam logic [63:0] DNAN = 64'h7FF8000000000000;
  localparam logic [63:0] QB = 64'h0008000000000000;

  task automatic expect_out(output logic efix, output logic [63:0] eres, output logic einv,
                            output logic [2:0] enorm, output string req);
    int a = cls(x), b = cls(y), c = cls(z);
    bit psign = x[63] ^ y[63];
    bit anyinf = (a == 3) || (b == 3);
    bit anyzero = (a == 0) || (b == 0);
    efix = 1; einv = 0; eres = 0; enorm = 0;
    if (c == 5)            begin req = "R1"; einv = 1; eres = z | QB; end
    else if (a == 5)       begin req = "R2"; einv = 1; eres = x | QB; end
    else if (b == 5)       begin req = "R2"; einv = 1; eres = y | QB; end
    else if (a == 4)       begin req = "R3"; eres = x; end
    else if (b == 4)       begin req = "R3"; eres = y; end
    else if (anyinf && anyzero) begin
      req = "R4";
      if (c == 4) eres = z; else begin einv = 1; eres = DNAN; end
    end else if (anyinf) begin
      req = "R5";
      if (c == 4) eres = z;
      else if (c == 3 && z[63] != psign) begin req = "R6"; einv = 1; eres = DNAN; end
      else eres = {psign, 11'h7FF, 52'd0};
    end else if (anyzero) begin
      req = "R7"; eres = z;
    end else if (c == 4 || c == 3) begin
      req = "R8"; eres = z;
    end else begin
      req = "R9"; efix = 0;
      enorm = {a == 1, b == 1, c == 1};
    end
    if (label_override != "") req = label_override;
  endtask

  task automatic compare();
    logic efix, einv;
    logic [63:0] eres;
    logic [2:0] enorm;
    string req;
    expect_out(efix, eres, einv, enorm, req);
    checks++;
    if (fixd !== efix || comp !== !efix) begin
      errors++;
      $display("FAIL %s fixed/compute got %b/%b exp %b/%b", req, fixd, comp, efix, !efix);
    end
    checks++;
    if (res !== eres) begin
      errors++;
      $display("FAIL %s result got %h exp %h (x=%h y=%h z=%h)", req, res, eres, x, y, z);
    end
    checks++;
    if (inv !== einv) begin
      errors++;
      $display("FAIL %s invalid got %b exp %b (x=%h y=%h z=%h)", req, inv, einv, x, y, z);
    end
    checks++;
    if ({nx, ny, nz} !== enorm) begin
      errors++;
      $display("FAIL %s normalize got %b exp %b", req, {nx, ny, nz}, enorm);
    end
  endtask

  task automatic apply(input logic [63:0] vx, input logic [63:0] vy, input logic [63:0] vz);
    @(posedge clk);
    x = vx; y = vy; z = vz;
    @(negedge clk);
    compare();
  endtask

  initial begin
    x = 0; y = 0; z = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    label_override = "R7 reset";
    compare();
    label_override = "";
    rst_n = 1'b1;
    // full class-triple sweep with every sign combination (R1..R9, R11)
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++)
          for (int c = 0; c < 6; c++)
            apply(mk(a, s[2]), mk(b, s[1]), mk(c, s[0]));
    // R10 classification boundaries around the quiet bit and exponent extremes
    label_override = "R10";
    apply(64'h7FF8000000000000, 64'h3FF0000000000000, 64'h0);
    apply(64'h7FF0000000000001, 64'h3FF0000000000000, 64'h0);
    apply(64'h3FF0000000000000, 64'h0000000000000001, 64'h7FF0000000000000);
    apply(64'h0000000000000001, 64'h0008000000000000, 64'h8000000000000001);
    apply(64'h7FEFFFFFFFFFFFFF, 64'h0010000000000000, 64'hFFF0000000000000);
    apply(64'h3FF0000000000000, 64'h3FF0000000000000, 64'hFFF4000000000000);
    // R11 default NaN and quieting encodings
    label_override = "R11";
    apply(64'h7FF0000000000000, 64'h8000000000000000, 64'h3FF0000000000000);
    apply(64'h3FF0000000000000, 64'h3FF0000000000000, 64'h7FF0000000000002);
    label_override = "";
    for (int i = 0; i < 2000; i++)
      apply(mk($urandom_range(5), 1'($urandom)), mk($urandom_range(5), 1'($urandom)),
            mk($urandom_range(5), 1'($urandom)));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule